// File: doc/BRIEF.md
# Boot-Swapping Chip-Select Decoder

This block sits between a CPU's two coarse chip-select lines and up to eight memory devices. It splits each coarse select into four fine selects, which gives one group of four outputs per input. The upper address bits pick the fine select inside a group. How those bits are divided depends on a small capacity register, with one field for each output group. That field sets how many 8 MB address regions each fine select spans. An address that falls past the fourth fine select of a group drives no output.

A boot-memory module can be plugged in, and an active-low detect line reports it. The block samples this line while reset is held. If the module is present, the two input selects change places: the CPU's boot select drives the group wired to the module, and the other select drives the original boot group. Each group keeps its own capacity setting. The mapping stays fixed until the next reset. The outputs are combinational from the selects and the address, so the decoder adds no cycle of latency. The power-enable and battery-fault inputs are accepted and have no effect on the outputs.

Top module: `bootSelDecoder`

## Requirements
- R1: Output bit g*4+s belongs to group g, fine select s, and is active low. With no swap, input select g drives group g, and fine select s is low when s equals adrHi shifted right by capacity field g.
- R2: A capacity field value c (0 to 3) gives each fine select 2^c regions of 8 MB, one region per adrHi step. When adrHi >> c is 4 or more, the whole group stays high.
- R3: Capacity field g occupies cfgData bits [2g+1:2g]. Every field resets to 3. A clock edge with cfgWe high loads all fields, and the new value takes effect from the next cycle.
- R4: modDetectN is sampled at each clock edge while rstN is low. The last sample before rstN rises is held, and later changes of modDetectN have no effect.
- R5: When the held sample showed modDetectN low, input select 0 drives group 1 using capacity field 1, and input select 1 drives group 0 using capacity field 0.
- R6: At most one output is low. When both selects are high, all outputs are high. When both are low, input select 0 wins.
- R7: pwrEn and battFault have no effect on any output.
- R8: The outputs follow csN and adrHi within the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 2 | Coarse chip selects, active low |
| adrHi | input | 3 | Upper address bits (region index of 8 MB) |
| modDetectN | input | 1 | Boot-module present, active low |
| pwrEn | input | 1 | Power enable, ignored |
| battFault | input | 1 | Battery fault, ignored |
| cfgWe | input | 1 | Capacity register write enable |
| cfgData | input | 4 | Capacity register write data |
| memSelN | output | 8 | Fine memory selects, active low |

## Verification
The assertions assume that csN, adrHi and cfgData settle well before each sampling edge. They also assume that rstN is synchronous and is held low for at least one edge after power-up, so that the swap flag and the capacity fields hold defined values. The stimulus holds rstN low across the first edge. It changes every input only just after a rising edge, so every sample the bench and the checker take sees stable values. modDetectN is toggled only inside or after reset windows that the bench tracks.

// File: rtl/bootSelPkg.sv
package bootSelPkg;
  localparam int unsigned GRP_CNT = 2;
  localparam int unsigned CAP_W   = 2;
  localparam int unsigned CFG_W   = GRP_CNT * CAP_W;

  typedef struct packed {
    logic             swapGroups;
    logic [CFG_W-1:0] capVec;
  } selCtrlT;
endpackage

// File: rtl/bootSelCtrl.sv
module bootSelCtrl
  import bootSelPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modDetectN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  output selCtrlT          ctrl
);
  logic             swapQ;
  logic [CFG_W-1:0] capQ;

  // swap flag tracks the detect line only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swapQ <= ~modDetectN;
      capQ  <= '1;
    end else if (cfgWe) begin
      capQ  <= cfgData;
    end
  end

  always_comb begin
    ctrl.swapGroups = swapQ;
    ctrl.capVec     = capQ;
  end
endmodule

// File: rtl/bootSelSubDecode.sv
module bootSelSubDecode #(
  parameter int unsigned SUBS  = 4,
  parameter int unsigned ADR_W = 3,
  parameter int unsigned CAP_W = 2
) (
  input  logic             hit,
  input  logic [ADR_W-1:0] adrHi,
  input  logic [CAP_W-1:0] cap,
  output logic [SUBS-1:0]  selN
);
  logic [ADR_W-1:0] idx;
  assign idx = adrHi >> cap;

  for (genvar s = 0; s < SUBS; s++) begin : g_sub
    assign selN[s] = ~(hit && (idx == ADR_W'(s)));
  end
endmodule

// File: rtl/bootSelDatapath.sv
module bootSelDatapath
  import bootSelPkg::*;
#(
  parameter int unsigned SUBS  = 4,
  parameter int unsigned ADR_W = 3,
  localparam int unsigned OUT_W = GRP_CNT * SUBS
) (
  input  logic [GRP_CNT-1:0] csN,
  input  logic [ADR_W-1:0]   adrHi,
  input  selCtrlT            ctrl,
  output logic [OUT_W-1:0]   memSelN
);
  logic [GRP_CNT-1:0] req;
  logic [GRP_CNT-1:0] grant;
  logic [GRP_CNT-1:0] groupHit;

  // lowest-index active select wins
  assign req   = ~csN;
  assign grant = req & (~req + GRP_CNT'(1));

  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    localparam int unsigned SRC = (g < 2) ? (g ^ 1) : g;
    assign groupHit[g] = ctrl.swapGroups ? grant[SRC] : grant[g];

    bootSelSubDecode #(
      .SUBS (SUBS),
      .ADR_W(ADR_W),
      .CAP_W(CAP_W)
    ) u_sub (
      .hit  (groupHit[g]),
      .adrHi(adrHi),
      .cap  (ctrl.capVec[g*CAP_W +: CAP_W]),
      .selN (memSelN[g*SUBS +: SUBS])
    );
  end
endmodule

// File: rtl/bootSelDecoder.sv
module bootSelDecoder
  import bootSelPkg::*;
#(
  parameter int unsigned SUBS  = 4,
  parameter int unsigned ADR_W = 3,
  localparam int unsigned OUT_W = GRP_CNT * SUBS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [GRP_CNT-1:0] csN,
  input  logic [ADR_W-1:0]   adrHi,
  input  logic               modDetectN,
  input  logic               pwrEn,
  input  logic               battFault,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgData,
  output logic [OUT_W-1:0]   memSelN
);
  selCtrlT ctrlBus;
  logic    unusedSideband;

  // power status lines are accepted but deliberately not decoded
  assign unusedSideband = pwrEn ^ battFault;

  bootSelCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modDetectN(modDetectN),
    .cfgWe     (cfgWe),
    .cfgData   (cfgData),
    .ctrl      (ctrlBus)
  );

  bootSelDatapath #(
    .SUBS (SUBS),
    .ADR_W(ADR_W)
  ) u_dp (
    .csN    (csN),
    .adrHi  (adrHi),
    .ctrl   (ctrlBus),
    .memSelN(memSelN)
  );
endmodule

// File: rtl/bootSelDecoderChk.sv
module bootSelDecoderChk
  import bootSelPkg::*;
#(
  parameter int unsigned SUBS = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [GRP_CNT-1:0]      csN,
  input logic                    cfgWe,
  input logic [CFG_W-1:0]        cfgData,
  input logic [CFG_W-1:0]        capVec,
  input logic                    swapFlag,
  input logic [GRP_CNT*SUBS-1:0] memSelN
);
  p_single_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memSelN));

  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> (&memSelN));

  p_cap_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (capVec == $past(cfgData)));

  p_swap_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(swapFlag));

  p_direct_src_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!swapFlag && !(&memSelN[SUBS-1:0])) |-> !csN[0]);

  p_swapped_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    (swapFlag && !(&memSelN[SUBS-1:0])) |-> !csN[1]);
endmodule

bind bootSelDecoder bootSelDecoderChk #(.SUBS(SUBS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .cfgWe   (cfgWe),
  .cfgData (cfgData),
  .capVec  (ctrlBus.capVec),
  .swapFlag(ctrlBus.swapGroups),
  .memSelN (memSelN)
);

// File: tb/bootSelDecoder_bench.sv
module bootSelDecoder_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] csN;
  logic [2:0] adrHi;
  logic       modDetectN;
  logic       pwrEn;
  logic       battFault;
  logic       cfgWe;
  logic [3:0] cfgData;
  logic [7:0] memSelN;

  int compared   = 0;
  int mismatched = 0;
  logic [3:0] capM;
  logic       swapM;

  always #10 clk = ~clk;

  bootSelDecoder u_bootSelDecoder (
    .clk(clk), .rstN(rstN), .csN(csN), .adrHi(adrHi),
    .modDetectN(modDetectN), .pwrEn(pwrEn), .battFault(battFault),
    .cfgWe(cfgWe), .cfgData(cfgData), .memSelN(memSelN)
  );

  // behavioural reference: select owner, target group, region slot
  function automatic logic [7:0] refSel(input logic [1:0] cs, input int adr,
                                        input logic [3:0] cap, input logic swp);
    logic [7:0] r = 8'hFF;
    int owner = -1;
    int grp;
    int slot;
    if (cs[0] == 1'b0) owner = 0;
    else if (cs[1] == 1'b0) owner = 1;
    if (owner >= 0) begin
      grp  = swp ? 1 - owner : owner;
      slot = adr / (1 << cap[grp*2 +: 2]);
      if (slot < 4) r[grp*4 + slot] = 1'b0;
    end
    return r;
  endfunction

  task automatic cyc(input logic [1:0] cs, input int adr, input logic we,
                     input logic [3:0] wd, input logic rst, input logic det,
                     input string tag);
    logic [7:0] expV;
    csN = cs; adrHi = 3'(adr); cfgWe = we; cfgData = wd; rstN = rst;
    modDetectN = det; pwrEn = 1'($urandom); battFault = 1'($urandom);
    @(negedge clk);
    expV = refSel(cs, adr, capM, swapM);
    compared++;
    if (memSelN !== expV) begin
      mismatched++;
      $display("FAIL %s: cs=%b adr=%0d cap=%h swap=%b actual=%b expected=%b",
               tag, cs, adr, capM, swapM, memSelN, expV);
    end
    @(posedge clk);
    if (!rst) begin swapM = ~det; capM = 4'hF; end
    else if (we) capM = wd;
    #1;
  endtask

  task automatic sweep(input logic det);
    for (int c = 0; c < 16; c++) begin
      cyc(2'b11, 0, 1'b1, 4'(c), 1'b1, det, "R3 R6");
      for (int p = 0; p < 4; p++) begin
        for (int a = 0; a < 8; a++) begin
          if (p == 0)      cyc(2'(p), a, 1'b0, 4'h0, 1'b1, det, "R6 R7");
          else if (swapM)  cyc(2'(p), a, 1'b0, 4'h0, 1'b1, det, "R5 R2 R7");
          else             cyc(2'(p), a, 1'b0, 4'h0, 1'b1, det, "R1 R2 R8");
        end
      end
    end
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 2'b11; adrHi = '0; modDetectN = 1'b1;
    pwrEn = 1'b0; battFault = 1'b0; cfgWe = 1'b0; cfgData = '0;
    @(posedge clk);
    swapM = 1'b0; capM = 4'hF;
    #1;
    // reset state: all high, capacity default 3 -> any address hits slot 0
    cyc(2'b11, 5, 1'b0, 4'h0, 1'b0, 1'b1, "R3 R6");
    cyc(2'b10, 7, 1'b0, 4'h0, 1'b0, 1'b1, "R3");
    cyc(2'b01, 3, 1'b0, 4'h0, 1'b0, 1'b1, "R3");
    sweep(1'b1);
    // write ignored while in reset
    cyc(2'b11, 0, 1'b1, 4'h0, 1'b0, 1'b1, "R3");
    cyc(2'b11, 0, 1'b0, 4'h0, 1'b0, 1'b0, "R4");
    cyc(2'b10, 6, 1'b0, 4'h0, 1'b1, 1'b1, "R4 R5");
    cyc(2'b01, 2, 1'b0, 4'h0, 1'b1, 1'b1, "R4 R5");
    sweep(1'b1);
    // detect seen low then high inside reset: last sample rules
    cyc(2'b11, 0, 1'b0, 4'h0, 1'b0, 1'b0, "R4");
    cyc(2'b11, 0, 1'b0, 4'h0, 1'b0, 1'b1, "R4");
    cyc(2'b10, 1, 1'b0, 4'h0, 1'b1, 1'b0, "R4 R1");
    cyc(2'b00, 4, 1'b0, 4'h0, 1'b1, 1'b0, "R4 R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule